// File: doc/BRIEF.md
# Display Adapter Indexed Register File

This block is the register front end of a virtual display adapter. Software reaches it through three small ports. A write to the selector port picks a register number. Reads and writes on the data port then reach the selected register. A third, spare port accepts any access and does nothing.

Behind the data port the block holds these registers:
- the adapter version tag
- display enable and configuration-complete flags
- pending width and height
- cursor state and a guest identifier
- an array of general-purpose scratch words

Several read values are not stored. The block derives them from the colour depth and the pending width: rounded bits per pixel, bytes per scan line, and the sizes of the frame, the video memory and the command area. It also returns fixed limits and a capability word. An access to a register number that does not exist reads as zero and raises a one-cycle `bad_access` pulse.

Read data comes back two clock cycles after the read request and is marked by `bus_rvalid`. Writes take effect at the clock edge that samples them.

Top module: `dispctl_regfile`

## Requirements
- R1: Port slot = `bus_addr >> STRIDE_LOG2`. Slot 0 is the selector port, slot 1 the data port and slot 2 the spare port. A read of slot 0 returns the 32-bit selected register number, which is 0 after reset. A read of any slot above 2 returns 0.
- R2: Every read request (`bus_valid` high, `bus_write` low) produces `bus_rvalid` high for exactly one cycle, two clock edges after the request. `bus_rdata` is valid in that cycle.
- R3: Register 0 holds the version tag and resets to 0x90000002. A write to it is kept only if the value is exactly 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the tag unchanged.
- R4: Fixed reads:
  - register 4 returns 2360
  - register 5 returns 1770
  - register 15 returns MEM_BYTES − 0x10000
  - register 18 returns MEM_BASE + MEM_BYTES − 0x10000
  - register 19 returns 0x10000
- R5: Registers 7 and 28 both return (depth + 7) with the low three bits cleared. Register 12 returns ((depth + 7) >> 3) × pending width. The pending width is written through register 2.
- R6: Register 1 is the enable. A write stores (value ≠ 0) and shows it on `disp_enable`. The same write latches frame size = ((depth + 7) >> 3) × width × height into register 16. A zero write also clears the configuration-complete flag, register 20.
- R7: Register 27 is the cursor switch. Writing 1 turns `cursor_visible` on and writing 0 turns it off. Any other value leaves it as it was.
- R8: Indices 1792 up to 1792 + SCRATCH_WORDS − 1 read and write scratch word (index − 1792). Register 29 returns SCRATCH_WORDS.
- R9: Register 17 returns a capability word:
  - bit 0 (rectangle fill) and bit 1 (rectangle copy) are always set
  - bits 5, 6 and 7 are set when HW_CURSOR is 1
  - all other bits are 0
- R10: A data-port access to an unknown index reads 0 and does not change any register or scratch word. It pulses `bad_access` for one cycle, one edge after the access. This includes index 1792 + SCRATCH_WORDS.
- R11: A write to register 7 whose value differs from the depth is rejected: register 7 keeps its value and `bad_access` pulses. A write equal to the depth raises no pulse.
- R12: Spare-port reads return 0. Spare-port writes change nothing and never raise `bad_access`.
- R13: Reset values: `disp_enable`, `cursor_visible` and `bad_access` are 0, width and height are 0, and register 6 reads the DEPTH parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Port address (slot × stride) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, two edges after the request |
| bad_access | output | 1 | One-cycle pulse for a rejected data-port access |
| disp_enable | output | 1 | Current enable register state |
| cursor_visible | output | 1 | Current cursor switch state |

## Verification
The bound checker watches several rules on every cycle:
- the read pipeline timing in both directions
- that the version tag never holds an illegal value
- the cursor switch encodings
- the effect of a zero enable on both flags
- that `bad_access` only follows a data-port access and never a spare-port one

The values themselves can only be shown by the bench's scenarios. These are:
- the derived pitch, depth and size reads
- scratch contents, including the boundary word just past the array
- the rejection of bad indices and mismatched depth writes, observed through later reads

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam logic [31:0] TAG_V0 = 32'h9000_0000;
  localparam logic [31:0] TAG_V1 = 32'h9000_0001;
  localparam logic [31:0] TAG_V2 = 32'h9000_0002;
  localparam logic [31:0] CMD_AREA_BYTES = 32'h0001_0000;

  localparam logic [31:0] RN_TAG       = 32'd0;
  localparam logic [31:0] RN_ENABLE    = 32'd1;
  localparam logic [31:0] RN_WIDTH     = 32'd2;
  localparam logic [31:0] RN_HEIGHT    = 32'd3;
  localparam logic [31:0] RN_LIM_W     = 32'd4;
  localparam logic [31:0] RN_LIM_H     = 32'd5;
  localparam logic [31:0] RN_DEPTH     = 32'd6;
  localparam logic [31:0] RN_BPP       = 32'd7;
  localparam logic [31:0] RN_PITCH     = 32'd12;
  localparam logic [31:0] RN_VMEM      = 32'd15;
  localparam logic [31:0] RN_FRAME     = 32'd16;
  localparam logic [31:0] RN_CAPS      = 32'd17;
  localparam logic [31:0] RN_CMD_START = 32'd18;
  localparam logic [31:0] RN_CMD_SIZE  = 32'd19;
  localparam logic [31:0] RN_CFG_DONE  = 32'd20;
  localparam logic [31:0] RN_SYNC      = 32'd21;
  localparam logic [31:0] RN_BUSY      = 32'd22;
  localparam logic [31:0] RN_GUEST     = 32'd23;
  localparam logic [31:0] RN_CUR_ID    = 32'd24;
  localparam logic [31:0] RN_CUR_X     = 32'd25;
  localparam logic [31:0] RN_CUR_Y     = 32'd26;
  localparam logic [31:0] RN_CUR_SW    = 32'd27;
  localparam logic [31:0] RN_HOST_BPP  = 32'd28;
  localparam logic [31:0] RN_SCR_CNT   = 32'd29;
  localparam logic [31:0] RN_SCR_BASE  = 32'd1792;

  typedef enum logic [1:0] {
    SLOT_SEL   = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_SPARE = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;
endpackage

// File: rtl/dispctl_slot_decode.sv
module dispctl_slot_decode
  import dispctl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STRIDE_LOG2 = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_e             slot
);
  logic [ADDR_W-1:0] slot_num;

  generate
    if (STRIDE_LOG2 == 0) begin : g_dense
      assign slot_num = addr;
    end else begin : g_spread
      assign slot_num = addr >> STRIDE_LOG2;
    end
  endgenerate

  always_comb begin
    if (slot_num == ADDR_W'(0))      slot = SLOT_SEL;
    else if (slot_num == ADDR_W'(1)) slot = SLOT_DATA;
    else if (slot_num == ADDR_W'(2)) slot = SLOT_SPARE;
    else                             slot = SLOT_NONE;
  end
endmodule

// File: rtl/dispctl_derive.sv
module dispctl_derive #(
  parameter int DIM_W = 12
) (
  input  logic [7:0]       depth,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  output logic [31:0]      bpp_rounded,
  output logic [31:0]      pitch,
  output logic [31:0]      frame_bytes
);
  logic [31:0] depth_up;
  logic [31:0] bytes_pp;

  always_comb begin
    depth_up    = {24'd0, depth} + 32'd7;
    bpp_rounded = depth_up & ~32'd7;
    bytes_pp    = depth_up >> 3;
    pitch       = bytes_pp * {{(32-DIM_W){1'b0}}, width};
    frame_bytes = pitch * {{(32-DIM_W){1'b0}}, height};
  end
endmodule

// File: rtl/dispctl_scratch_ram.sv
module dispctl_scratch_ram #(
  parameter int WORDS = 64,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dispctl_regfile.sv
module dispctl_regfile
  import dispctl_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          STRIDE_LOG2   = 0,
  parameter int          DIM_W         = 12,
  parameter int          DEPTH         = 24,
  parameter int          SCRATCH_WORDS = 64,
  parameter logic [31:0] MEM_BYTES     = 32'h0080_0000,
  parameter logic [31:0] MEM_BASE      = 32'hE000_0000,
  parameter bit          HW_CURSOR     = 1'b1,
  parameter int          LIMIT_W       = 2360,
  parameter int          LIMIT_H       = 1770
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bad_access,
  output logic              disp_enable,
  output logic              cursor_visible
);
  localparam int SCR_AW = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [7:0]  DEPTH_V = 8'(DEPTH);
  localparam logic [31:0] CAPS_V  = 32'h3 | (HW_CURSOR ? 32'hE0 : 32'h0);

  slot_e            slot;
  logic [31:0]      index_q, tag_q, guest_q, cur_id_q, cur_x_q, cur_y_q, frame_q;
  logic [DIM_W-1:0] width_q, height_q;
  logic [7:0]       bpp_q;
  logic             cfg_done_q;
  logic [31:0]      bpp_rounded, pitch, frame_bytes, scr_diff, scr_rdata, reg_val;
  logic             data_acc, data_wr, scr_hit, known, reject;
  logic             rd_p1, scr_sel_p1;
  logic [31:0]      reg_p1;

  dispctl_slot_decode #(.ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)) u_dec (
    .addr(bus_addr), .slot(slot));

  dispctl_derive #(.DIM_W(DIM_W)) u_derive (
    .depth(bpp_q), .width(width_q), .height(height_q),
    .bpp_rounded(bpp_rounded), .pitch(pitch), .frame_bytes(frame_bytes));

  assign data_acc = bus_valid && (slot == SLOT_DATA);
  assign data_wr  = data_acc && bus_write;
  assign scr_diff = index_q - RN_SCR_BASE;
  assign scr_hit  = (index_q >= RN_SCR_BASE) && (scr_diff < 32'(SCRATCH_WORDS));

  dispctl_scratch_ram #(.WORDS(SCRATCH_WORDS)) u_scr (
    .clk(clk), .we(data_wr && scr_hit), .addr(scr_diff[SCR_AW-1:0]),
    .wdata(bus_wdata), .rdata(scr_rdata));

  always_comb begin
    known   = 1'b1;
    reg_val = 32'd0;
    case (index_q)
      RN_TAG:       reg_val = tag_q;
      RN_ENABLE:    reg_val = {31'd0, disp_enable};
      RN_WIDTH:     reg_val = {{(32-DIM_W){1'b0}}, width_q};
      RN_HEIGHT:    reg_val = {{(32-DIM_W){1'b0}}, height_q};
      RN_LIM_W:     reg_val = 32'(LIMIT_W);
      RN_LIM_H:     reg_val = 32'(LIMIT_H);
      RN_DEPTH:     reg_val = {24'd0, DEPTH_V};
      RN_BPP:       reg_val = bpp_rounded;
      RN_PITCH:     reg_val = pitch;
      RN_VMEM:      reg_val = MEM_BYTES - CMD_AREA_BYTES;
      RN_FRAME:     reg_val = frame_q;
      RN_CAPS:      reg_val = CAPS_V;
      RN_CMD_START: reg_val = MEM_BASE + MEM_BYTES - CMD_AREA_BYTES;
      RN_CMD_SIZE:  reg_val = CMD_AREA_BYTES;
      RN_CFG_DONE:  reg_val = {31'd0, cfg_done_q};
      RN_SYNC:      reg_val = 32'd0;
      RN_BUSY:      reg_val = 32'd0;
      RN_GUEST:     reg_val = guest_q;
      RN_CUR_ID:    reg_val = cur_id_q;
      RN_CUR_X:     reg_val = cur_x_q;
      RN_CUR_Y:     reg_val = cur_y_q;
      RN_CUR_SW:    reg_val = {31'd0, cursor_visible};
      RN_HOST_BPP:  reg_val = bpp_rounded;
      RN_SCR_CNT:   reg_val = 32'(SCRATCH_WORDS);
      default:      known   = 1'b0;
    endcase
    reject = data_acc && ((!known && !scr_hit) ||
             (bus_write && index_q == RN_BPP && bus_wdata != {24'd0, bpp_q}));
  end

  // register writes and the error pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= 32'd0;       tag_q <= TAG_V2;     guest_q <= 32'd0;
      cur_id_q <= 32'd0;      cur_x_q <= 32'd0;    cur_y_q <= 32'd0;
      frame_q <= 32'd0;       width_q <= '0;       height_q <= '0;
      bpp_q <= DEPTH_V;       cfg_done_q <= 1'b0;  disp_enable <= 1'b0;
      cursor_visible <= 1'b0; bad_access <= 1'b0;
    end else begin
      bad_access <= reject;
      if (bus_valid && bus_write && slot == SLOT_SEL) index_q <= bus_wdata;
      if (data_wr) begin
        case (index_q)
          RN_TAG:
            if (bus_wdata == TAG_V0 || bus_wdata == TAG_V1 || bus_wdata == TAG_V2)
              tag_q <= bus_wdata;
          RN_ENABLE: begin
            disp_enable <= |bus_wdata;
            if (bus_wdata == 32'd0) cfg_done_q <= 1'b0;
            frame_q <= frame_bytes;
          end
          RN_WIDTH:    width_q  <= bus_wdata[DIM_W-1:0];
          RN_HEIGHT:   height_q <= bus_wdata[DIM_W-1:0];
          RN_CFG_DONE: cfg_done_q <= |bus_wdata;
          RN_GUEST:    guest_q  <= bus_wdata;
          RN_CUR_ID:   cur_id_q <= bus_wdata;
          RN_CUR_X:    cur_x_q  <= bus_wdata;
          RN_CUR_Y:    cur_y_q  <= bus_wdata;
          RN_CUR_SW:
            if (bus_wdata == 32'd1)      cursor_visible <= 1'b1;
            else if (bus_wdata == 32'd0) cursor_visible <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // two-stage read pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1 <= 1'b0; scr_sel_p1 <= 1'b0; reg_p1 <= 32'd0;
      bus_rvalid <= 1'b0; bus_rdata <= 32'd0;
    end else begin
      rd_p1      <= bus_valid && !bus_write;
      scr_sel_p1 <= data_acc && scr_hit;
      case (slot)
        SLOT_SEL:  reg_p1 <= index_q;
        SLOT_DATA: reg_p1 <= reg_val;
        default:   reg_p1 <= 32'd0;
      endcase
      bus_rvalid <= rd_p1;
      bus_rdata  <= scr_sel_p1 ? scr_rdata : reg_p1;
    end
  end
endmodule

// File: rtl/dispctl_regfile_chk.sv
module dispctl_regfile_chk #(
  parameter int ADDR_W      = 4,
  parameter int STRIDE_LOG2 = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              bad_access,
  input logic              disp_enable,
  input logic              cursor_visible,
  input logic [31:0]       index_q,
  input logic [31:0]       tag_q,
  input logic              cfg_done_q
);
  logic [ADDR_W-1:0] slot_num;
  logic data_wr, data_acc, rd_req;
  assign slot_num = bus_addr >> STRIDE_LOG2;
  assign rd_req   = bus_valid && !bus_write;
  assign data_acc = bus_valid && slot_num == ADDR_W'(1);
  assign data_wr  = data_acc && bus_write;

  a_r2_rvalid_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ##1 bus_rvalid);
  a_r2_rvalid_origin: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(rd_req, 2));
  a_r3_tag_legal: assert property (@(posedge clk) disable iff (rst)
    (tag_q == 32'h9000_0000 || tag_q == 32'h9000_0001 || tag_q == 32'h9000_0002));
  a_r6_enable_zero: assert property (@(posedge clk) disable iff (rst)
    (data_wr && index_q == 32'd1 && bus_wdata == 32'd0) |=> (!disp_enable && !cfg_done_q));
  a_r7_cursor_on: assert property (@(posedge clk) disable iff (rst)
    (data_wr && index_q == 32'd27 && bus_wdata == 32'd1) |=> cursor_visible);
  a_r7_cursor_off: assert property (@(posedge clk) disable iff (rst)
    (data_wr && index_q == 32'd27 && bus_wdata == 32'd0) |=> !cursor_visible);
  a_r7_cursor_hold: assert property (@(posedge clk) disable iff (rst)
    (data_wr && index_q == 32'd27 && bus_wdata > 32'd1) |=> $stable(cursor_visible));
  a_r10_bad_origin: assert property (@(posedge clk) disable iff (rst)
    bad_access |-> $past(data_acc));
  a_r12_spare_quiet: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && slot_num == ADDR_W'(2)) |=> !bad_access);
endmodule

bind dispctl_regfile dispctl_regfile_chk #(.ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .bad_access(bad_access), .disp_enable(disp_enable),
  .cursor_visible(cursor_visible), .index_q(index_q), .tag_q(tag_q),
  .cfg_done_q(cfg_done_q));

// File: tb/sim_dispctl_regfile.sv
module sim_dispctl_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int NSCR = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bad_access, disp_enable, cursor_visible;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic last_bad, last_rv;
  logic [31:0] last_rd;
  logic [31:0] scr_model [NSCR];

  always #(CLK_PERIOD/2) clk = ~clk;

  dispctl_regfile u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bad_access(bad_access),
    .disp_enable(disp_enable), .cursor_visible(cursor_visible));

  function automatic logic [31:0] exp_bpp(input int d);
    return 32'((d + 7) & ~7);
  endfunction
  function automatic logic [31:0] exp_pitch(input int d, input logic [31:0] w);
    return 32'((d + 7) >> 3) * w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    last_bad = bad_access;
    bus_valid = 1'b0; bus_write = 1'b0;
    @(posedge clk); @(negedge clk);
    last_rd = bus_rdata; last_rv = bus_rvalid;
  endtask

  task automatic wreg(input logic [31:0] idx, input logic [31:0] v);
    acc(1'b1, 4'd0, idx); acc(1'b1, 4'd1, v);
  endtask
  task automatic rreg(input logic [31:0] idx);
    acc(1'b1, 4'd0, idx); acc(1'b0, 4'd1, 32'd0);
  endtask
  task automatic expect_reg(input logic [31:0] idx, input logic [31:0] e, input string req);
    rreg(idx);
    chk(last_rd == e, req, last_rd, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic cur_model;
    logic [31:0] tag_model, w, v, idx;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R13 reset state
    chk(disp_enable == 1'b0, "R13 enable", {31'd0, disp_enable}, 0);
    chk(cursor_visible == 1'b0, "R13 cursor", {31'd0, cursor_visible}, 0);
    chk(bad_access == 1'b0, "R13 bad", {31'd0, bad_access}, 0);
    acc(1'b0, 4'd0, 0);
    chk(last_rd == 32'd0, "R1 index reset", last_rd, 0);
    chk(last_rv == 1'b1, "R2 rvalid", {31'd0, last_rv}, 1);
    @(negedge clk);
    chk(bus_rvalid == 1'b0, "R2 single pulse", {31'd0, bus_rvalid}, 0);
    expect_reg(2, 0, "R13 width");
    expect_reg(3, 0, "R13 height");
    expect_reg(6, 24, "R13 depth");
    acc(1'b0, 4'd0, 0);
    chk(last_rd == 32'd6, "R1 index readback", last_rd, 6);
    acc(1'b0, 4'd3, 0);
    chk(last_rd == 32'd0, "R1 unmapped slot", last_rd, 0);

    // R3 version tag
    tag_model = 32'h9000_0002;
    expect_reg(0, tag_model, "R3 reset tag");
    for (int i = 0; i < 12; i++) begin
      case ($urandom_range(0, 3))
        0: v = 32'h9000_0000;
        1: v = 32'h9000_0001;
        2: v = 32'h9000_0003;
        default: v = $urandom();
      endcase
      wreg(0, v);
      if (v == 32'h9000_0000 || v == 32'h9000_0001 || v == 32'h9000_0002) tag_model = v;
      expect_reg(0, tag_model, "R3 tag write");
    end

    // R4 fixed values
    expect_reg(4, 2360, "R4 width limit");
    expect_reg(5, 1770, "R4 height limit");
    expect_reg(15, 32'h007F_0000, "R4 vmem size");
    expect_reg(18, 32'hE07F_0000, "R4 cmd start");
    expect_reg(19, 32'h0001_0000, "R4 cmd size");

    // R5 derived depth and pitch
    expect_reg(7, exp_bpp(24), "R5 bpp");
    expect_reg(28, exp_bpp(24), "R5 host bpp");
    for (int i = 0; i < 8; i++) begin
      w = 32'($urandom_range(0, 4095));
      wreg(2, w);
      expect_reg(12, exp_pitch(24, w), "R5 pitch");
    end

    // R6 enable, frame size, config flag
    wreg(2, 640); wreg(3, 480); wreg(1, 1);
    chk(disp_enable == 1'b1, "R6 enable on", {31'd0, disp_enable}, 1);
    expect_reg(16, 32'd921600, "R6 frame size");
    wreg(20, 1);
    expect_reg(20, 1, "R6 cfg set");
    wreg(1, 0);
    chk(disp_enable == 1'b0, "R6 enable off", {31'd0, disp_enable}, 0);
    expect_reg(20, 0, "R6 cfg cleared");

    // R7 cursor switch
    cur_model = 1'b0;
    for (int i = 0; i < 16; i++) begin
      v = 32'($urandom_range(0, 3));
      wreg(27, v);
      if (v == 32'd1) cur_model = 1'b1;
      else if (v == 32'd0) cur_model = 1'b0;
      chk(cursor_visible == cur_model, "R7 cursor", {31'd0, cursor_visible}, {31'd0, cur_model});
    end

    // R8 scratch array
    expect_reg(29, NSCR, "R8 scratch count");
    for (int i = 0; i < NSCR; i++) begin
      scr_model[i] = $urandom();
      wreg(32'd1792 + 32'(i), scr_model[i]);
    end
    for (int i = 0; i < 30; i++) begin
      idx = 32'($urandom_range(0, NSCR - 1));
      scr_model[idx] = $urandom();
      wreg(32'd1792 + idx, scr_model[idx]);
    end
    for (int i = 0; i < NSCR; i++)
      expect_reg(32'd1792 + 32'(i), scr_model[i], "R8 scratch read");

    // R9 capabilities
    expect_reg(17, 32'h0000_00E3, "R9 caps");

    // R10 unknown indices
    rreg(40);
    chk(last_bad == 1'b1, "R10 bad read pulse", {31'd0, last_bad}, 1);
    chk(last_rd == 32'd0, "R10 bad read zero", last_rd, 0);
    chk(bad_access == 1'b0, "R10 pulse ends", {31'd0, bad_access}, 0);
    wreg(32'd1792 + NSCR, 32'hDEAD_BEEF);
    chk(last_bad == 1'b1, "R10 past end pulse", {31'd0, last_bad}, 1);
    wreg(32'd1791, 32'hCAFE_0001);
    chk(last_bad == 1'b1, "R10 below base pulse", {31'd0, last_bad}, 1);
    expect_reg(32'd1792, scr_model[0], "R10 scratch untouched");
    expect_reg(32'd1792 + NSCR - 1, scr_model[NSCR-1], "R10 last word untouched");
    wreg(5, 7);
    chk(last_bad == 1'b0, "R10 known read-only no pulse", {31'd0, last_bad}, 0);

    // R11 depth write rule
    wreg(7, 16);
    chk(last_bad == 1'b1, "R11 mismatch pulse", {31'd0, last_bad}, 1);
    expect_reg(7, exp_bpp(24), "R11 unchanged");
    wreg(7, 24);
    chk(last_bad == 1'b0, "R11 match no pulse", {31'd0, last_bad}, 0);

    // R12 spare port
    acc(1'b1, 4'd0, 32'd17);
    acc(1'b1, 4'd2, 32'h1234_5678);
    chk(last_bad == 1'b0, "R12 spare write quiet", {31'd0, last_bad}, 0);
    acc(1'b0, 4'd2, 0);
    chk(last_rd == 32'd0, "R12 spare read zero", last_rd, 0);
    chk(last_bad == 1'b0, "R12 spare read quiet", {31'd0, last_bad}, 0);
    acc(1'b0, 4'd0, 0);
    chk(last_rd == 32'd17, "R12 index kept", last_rd, 17);
    acc(1'b0, 4'd1, 0);
    chk(last_rd == 32'h0000_00E3, "R12 data port intact", last_rd, 32'hE3);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule